// File: doc/BRIEF.md
# Layer-Balancing Packet Injection Demultiplexer

This block sits under a column of four stacked tiles and feeds the routers of four device layers. Every tile injects fixed-length packets into its own port. The block forwards each packet in one vertical hop to the injection port of the router on a layer it draws at random. Spreading the packets this way keeps the load on the four horizontal planes even. Each source port has a small input buffer, and upstream flow control uses credits: the block hands back one credit per flit it drains. The downstream routers return credits per virtual channel.

On the head flit of a packet, the block picks a target layer from a free-running LFSR. It then claims a free virtual channel on that layer that holds at least one credit. The port is locked to that layer and channel until its tail flit has left. Ports that compete for the same layer output are served by a round-robin arbiter on that layer. A port that loses simply holds its flit for a later cycle.

Top module: `layer_inject_demux`

## Requirements
- R1: While reset is asserted, and afterwards until a flit is accepted, every `out_valid` and every `in_credit` bit is low.
- R2: Every packet of PKT_FLITS (5) flits from one port leaves intact and in order. All of its flits go to one layer output and one VC, with the payload unchanged. The first flit carries `out_head`=1 and the last carries `out_tail`=1, as counted by a per-port flit counter.
- R3: On every layer, no VC ever has more than VC_CREDITS (5) flits outstanding. A send and a credit return for the same VC in the same cycle leave its count unchanged. If no credit is returned, each VC carries exactly one packet and further heads stall.
- R4: A VC on a layer belongs to one packet from its head to its tail. No other head is given that VC meanwhile.
- R5: The layer for a head flit is drawn from a 16-bit Fibonacci LFSR (feedback from bits 15, 13, 12 and 10, nonzero seed) that steps every cycle. Port p reads bits [2p+1:2p]. Over a long run, each layer receives at least one eighth of all packets.
- R6: Each layer output has a round-robin arbiter. A locked port that keeps requesting loses at most NPORT-1 times in a row. A port that loses keeps its flit, and under full load from all ports every packet is delivered.
- R7: `in_credit[p]` pulses once for each flit drained from port p's buffer. The pulse appears in the cycle after the flit leaves. An upstream holding BUF_DEPTH (5) credits never overfills the buffer.
- R8: A credit returned on `ret_valid`/`ret_vc` restores that VC's capacity, so a head stalled for lack of credit proceeds once credits come back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Flit written into the port buffer |
| in_data | input | NPORT x DW | Flit payload per port |
| in_credit | output | NPORT | One-cycle credit pulse per drained flit |
| out_valid | output | NLAYER | Flit presented to the layer router |
| out_data | output | NLAYER x DW | Flit payload per layer |
| out_vc | output | NLAYER x VCW | Virtual channel of the flit |
| out_head | output | NLAYER | Flit is the first of its packet |
| out_tail | output | NLAYER | Flit is the last of its packet |
| ret_valid | input | NLAYER | Credit returned by the layer router |
| ret_vc | input | NLAYER x VCW | VC the returned credit belongs to |

## Verification
A flit written at one rising edge appears on a layer output one edge later at the earliest. Its `in_credit` pulse appears in the same cycle. A credit returned before an edge can fund a grant in the following cycle. The bench samples all outputs at falling edges. The target layer is random and arbitration adds delay, so the bench does not assume any fixed cycle for a packet. It scores every output flit against a per-port sequence model as the flit appears. Its end-of-phase checks run only after a drain wait, when no flits or credits remain in flight.

// File: rtl/ljd_pkg.sv
package ljd_pkg;

  // Fibonacci LFSR step, feedback from bits 15, 13, 12, 10.
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  // Layer drawn for a port: field of selw bits at port*selw, folded to nlayer.
  function automatic int unsigned pick_layer(input logic [15:0] s, input int unsigned port,
                                             input int unsigned selw, input int unsigned nlayer);
    int unsigned field;
    field = 32'(s >> (port * selw)) & ((32'd1 << selw) - 32'd1);
    return field % nlayer;
  endfunction

  // Credit count after one cycle of sends and returns.
  function automatic int unsigned credit_next(input int unsigned cnt, input logic take,
                                               input logic give);
    return cnt - (take ? 32'd1 : 32'd0) + (give ? 32'd1 : 32'd0);
  endfunction

endpackage

// File: rtl/ljd_in_fifo.sv
module ljd_in_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          nonempty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout     = mem[rd_ptr];
  assign nonempty = (cnt != '0);

  // R7: upstream credits keep the buffer from overfilling
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt != CW'(DEPTH)));
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);

endmodule

// File: rtl/ljd_rr_arb.sv
module ljd_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      int unsigned c;
      c = (32'(ptr) + 32'(i)) % 32'(N);
      if (!any && req[c]) begin
        any    = 1'b1;
        gnt[c] = 1'b1;
        idx    = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (any) ptr <= (idx == IW'(N - 1)) ? '0 : idx + 1'b1;
  end

  assert_arb_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_arb_grant_requested_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/ljd_vc_credits.sv
module ljd_vc_credits import ljd_pkg::*; #(
  parameter int NVC  = 2,
  parameter int INIT = 5,
  localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic [VCW-1:0] take_vc,
  input  logic           give,
  input  logic [VCW-1:0] give_vc,
  output logic [NVC-1:0] avail
);
  localparam int CW = $clog2(INIT + 1);

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    logic [CW-1:0] cnt;
    logic          take_v, give_v;

    assign take_v   = take && (take_vc == VCW'(v));
    assign give_v   = give && (give_vc == VCW'(v));
    assign avail[v] = (cnt != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) cnt <= CW'(INIT);
      else        cnt <= CW'(credit_next(32'(cnt), take_v, give_v));
    end

    // R3: never send without a credit, never hold more than the initial count
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take_v |-> (cnt != '0));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      give_v |-> ((cnt != CW'(INIT)) || take_v));
  end

endmodule

// File: rtl/layer_inject_demux.sv
module layer_inject_demux import ljd_pkg::*; #(
  parameter int          NPORT      = 4,
  parameter int          NLAYER     = 4,
  parameter int          NVC        = 2,
  parameter int          DW         = 16,
  parameter int          BUF_DEPTH  = 5,
  parameter int          VC_CREDITS = 5,
  parameter int          PKT_FLITS  = 5,
  parameter logic [15:0] LFSR_SEED  = 16'hB5A3,
  localparam int         VCW        = (NVC > 1) ? $clog2(NVC) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][DW-1:0]      in_data,
  output logic [NPORT-1:0]              in_credit,
  output logic [NLAYER-1:0]             out_valid,
  output logic [NLAYER-1:0][DW-1:0]     out_data,
  output logic [NLAYER-1:0][VCW-1:0]    out_vc,
  output logic [NLAYER-1:0]             out_head,
  output logic [NLAYER-1:0]             out_tail,
  input  logic [NLAYER-1:0]             ret_valid,
  input  logic [NLAYER-1:0][VCW-1:0]    ret_vc
);
  localparam int LW  = (NLAYER > 1) ? $clog2(NLAYER) : 1;
  localparam int PW  = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int FCW = (PKT_FLITS > 1) ? $clog2(PKT_FLITS) : 1;
  localparam int LCW = $clog2(NPORT + 1);

  // per-port state and events
  logic [NPORT-1:0][DW-1:0]  fifo_dout;
  logic [NPORT-1:0]          fifo_ne;
  logic [NPORT-1:0]          pgnt;
  logic [NPORT-1:0][FCW-1:0] fcnt;
  logic [NPORT-1:0][LW-1:0]  lock_layer;
  logic [NPORT-1:0][VCW-1:0] lock_vc;
  logic [NPORT-1:0]          is_head, is_tail, eligible;
  logic [NPORT-1:0][LW-1:0]  want_layer;
  logic [NPORT-1:0][VCW-1:0] want_vc;
  logic [NPORT-1:0][LCW-1:0] lose_cnt;

  // per-layer state and events
  logic [NLAYER-1:0][NVC-1:0]   avail;
  logic [NLAYER-1:0][NVC-1:0]   vc_busy;
  logic [NLAYER-1:0][NPORT-1:0] req, gnt;
  logic [NLAYER-1:0]            lsend, l_head, l_tail;
  logic [NLAYER-1:0][PW-1:0]    lidx;
  logic [NLAYER-1:0][VCW-1:0]   l_vc;

  logic [15:0] lfsr;

  // ---------------- input buffers ----------------
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ljd_in_fifo #(.DW(DW), .DEPTH(BUF_DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (in_valid[p]),
      .din      (in_data[p]),
      .pop      (pgnt[p]),
      .dout     (fifo_dout[p]),
      .nonempty (fifo_ne[p])
    );
  end

  // ---------------- random layer source ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= lfsr_step(lfsr);
  end

  // ---------------- route selection and VC allocation ----------------
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      logic found;
      found         = 1'b0;
      is_head[p]    = (fcnt[p] == '0);
      is_tail[p]    = (fcnt[p] == FCW'(PKT_FLITS - 1));
      want_layer[p] = '0;
      want_vc[p]    = '0;
      if (is_head[p]) begin
        want_layer[p] = LW'(pick_layer(lfsr, 32'(p), 32'(LW), 32'(NLAYER)));
        for (int v = 0; v < NVC; v++) begin
          if (!found && !vc_busy[want_layer[p]][v] && avail[want_layer[p]][v]) begin
            found      = 1'b1;
            want_vc[p] = VCW'(v);
          end
        end
        eligible[p] = fifo_ne[p] && found;
      end else begin
        want_layer[p] = lock_layer[p];
        want_vc[p]    = lock_vc[p];
        eligible[p]   = fifo_ne[p] && avail[lock_layer[p]][lock_vc[p]];
      end
    end
  end

  always_comb begin
    for (int l = 0; l < NLAYER; l++)
      for (int p = 0; p < NPORT; p++)
        req[l][p] = eligible[p] && (want_layer[p] == LW'(l));
  end

  // ---------------- switch arbitration and credits per layer ----------------
  for (genvar l = 0; l < NLAYER; l++) begin : g_layer
    ljd_rr_arb #(.N(NPORT)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req[l]),
      .gnt   (gnt[l]),
      .any   (lsend[l]),
      .idx   (lidx[l])
    );

    ljd_vc_credits #(.NVC(NVC), .INIT(VC_CREDITS)) u_cred (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (lsend[l]),
      .take_vc (l_vc[l]),
      .give    (ret_valid[l]),
      .give_vc (ret_vc[l]),
      .avail   (avail[l])
    );

    assign l_vc[l]   = want_vc[lidx[l]];
    assign l_head[l] = is_head[lidx[l]];
    assign l_tail[l] = is_tail[lidx[l]];

    // R4: a head only claims a VC that no packet holds
    assert_head_vc_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lsend[l] && l_head[l]) |-> !vc_busy[l][l_vc[l]]);
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      pgnt[p] = 1'b0;
      for (int l = 0; l < NLAYER; l++) pgnt[p] = pgnt[p] | gnt[l][p];
    end
  end

  // ---------------- flit counters and packet lock ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt       <= '0;
      lock_layer <= '0;
      lock_vc    <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (pgnt[p]) begin
          fcnt[p] <= is_tail[p] ? '0 : fcnt[p] + 1'b1;
          if (is_head[p]) begin
            lock_layer[p] <= want_layer[p];
            lock_vc[p]    <= want_vc[p];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vc_busy <= '0;
    end else begin
      for (int l = 0; l < NLAYER; l++) begin
        for (int v = 0; v < NVC; v++) begin
          if (lsend[l] && (l_vc[l] == VCW'(v))) begin
            if (l_tail[l])      vc_busy[l][v] <= 1'b0;
            else if (l_head[l]) vc_busy[l][v] <= 1'b1;
          end
        end
      end
    end
  end

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
      out_vc    <= '0;
      out_head  <= '0;
      out_tail  <= '0;
      in_credit <= '0;
    end else begin
      in_credit <= pgnt;
      for (int l = 0; l < NLAYER; l++) begin
        out_valid[l] <= lsend[l];
        out_data[l]  <= fifo_dout[lidx[l]];
        out_vc[l]    <= l_vc[l];
        out_head[l]  <= lsend[l] && l_head[l];
        out_tail[l]  <= lsend[l] && l_tail[l];
      end
    end
  end

  // ---------------- fairness watch ----------------
  for (genvar p = 0; p < NPORT; p++) begin : g_watch
    always_ff @(posedge clk) begin
      if (!rst_n)                                   lose_cnt[p] <= '0;
      else if (!is_head[p] && eligible[p] && !pgnt[p]) lose_cnt[p] <= lose_cnt[p] + 1'b1;
      else                                          lose_cnt[p] <= '0;
    end

    assert_locked_wait_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lose_cnt[p] < LCW'(NPORT));
    // R2: body flits follow the layer latched on the head
    assert_body_stays_on_layer_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pgnt[p] && !is_head[p]) |-> gnt[lock_layer[p]][p]);
  end

  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);

endmodule

// File: tb/layer_inject_demux_bench.sv
module layer_inject_demux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4, NL = 4, NV = 2, DW = 16, DEPTH = 5, CRED = 5, PKT = 5;
  localparam int SAT_PKTS = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]          in_valid = '0;
  logic [NP-1:0][DW-1:0]  in_data = '0;
  logic [NP-1:0]          in_credit;
  logic [NL-1:0]          out_valid;
  logic [NL-1:0][DW-1:0]  out_data;
  logic [NL-1:0][0:0]     out_vc;
  logic [NL-1:0]          out_head, out_tail;
  logic [NL-1:0]          ret_valid = '0;
  logic [NL-1:0][0:0]     ret_vc = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  layer_inject_demux u_layer_inject_demux (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_credit(in_credit),
    .out_valid(out_valid), .out_data(out_data), .out_vc(out_vc), .out_head(out_head),
    .out_tail(out_tail), .ret_valid(ret_valid), .ret_vc(ret_vc)
  );

  // written by the main process only
  int checks = 0, failures = 0;
  bit ret_en = 1'b0;
  int req_flits[NP] = '{default: 0};

  // written by the monitor only
  int mon_checks = 0, mon_fails = 0, cyc = 0, rx_total = 0;
  int tx_seq[NP] = '{default: 0};
  int up_cred[NP] = '{default: DEPTH};
  int exp_seq[NP] = '{default: 0};
  int cred_pulse[NP] = '{default: 0};
  int pkt_layer[NP] = '{default: -1};
  int pkt_vc[NP] = '{default: -1};
  int outst[NL][NV] = '{default: 0};
  int pend[NL][NV] = '{default: 0};
  int vc_owner[NL][NV] = '{default: -1};
  int vc_cnt[NL][NV] = '{default: 0};
  int layer_pkts[NL] = '{default: 0};

  bit wd_fail = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input string what, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor, downstream credit model and upstream driver, all at the falling edge
  always @(negedge clk) begin
    int pt, sq, v, vv;
    bit hd, tl;
    if (rst_n) begin
      for (int p = 0; p < NP; p++)
        if (in_credit[p]) begin
          up_cred[p]++;
          cred_pulse[p]++;
        end
      for (int l = 0; l < NL; l++) begin
        if (out_valid[l]) begin
          pt = int'(out_data[l][15:14]);
          sq = int'(out_data[l][13:0]);
          v  = int'(out_vc[l]);
          mchk(sq == exp_seq[pt], "R2", "flit order", sq, exp_seq[pt]);
          exp_seq[pt] = sq + 1;
          hd = (sq % PKT) == 0;
          tl = (sq % PKT) == PKT - 1;
          mchk(out_head[l] == hd, "R2", "head flag", int'(out_head[l]), int'(hd));
          mchk(out_tail[l] == tl, "R2", "tail flag", int'(out_tail[l]), int'(tl));
          if (hd) begin
            mchk(vc_owner[l][v] < 0, "R4", "head on held VC", vc_owner[l][v], -1);
            vc_owner[l][v] = pt;
            pkt_layer[pt] = l;
            pkt_vc[pt] = v;
            layer_pkts[l]++;
          end else begin
            mchk(vc_owner[l][v] == pt, "R4", "VC owner", vc_owner[l][v], pt);
            mchk(pkt_layer[pt] == l, "R2", "layer kept", l, pkt_layer[pt]);
            mchk(pkt_vc[pt] == v, "R2", "VC kept", v, pkt_vc[pt]);
          end
          if (tl) vc_owner[l][v] = -1;
          outst[l][v]++;
          mchk(outst[l][v] <= CRED, "R3", "outstanding flits", outst[l][v], CRED);
          pend[l][v]++;
          vc_cnt[l][v]++;
          rx_total++;
        end
      end
      for (int l = 0; l < NL; l++) begin
        ret_valid[l] = 1'b0;
        if (ret_en && (cyc % 3) != 1) begin
          for (int k = 0; k < NV; k++) begin
            vv = (cyc + l + k) % NV;
            if (!ret_valid[l] && pend[l][vv] > 0) begin
              ret_valid[l] = 1'b1;
              ret_vc[l] = 1'(vv);
              pend[l][vv]--;
              outst[l][vv]--;
            end
          end
        end
      end
      for (int p = 0; p < NP; p++) begin
        in_valid[p] = 1'b0;
        if (tx_seq[p] < req_flits[p] && up_cred[p] > 0) begin
          in_valid[p] = 1'b1;
          in_data[p] = {2'(p), 14'(tx_seq[p])};
          tx_seq[p]++;
          up_cred[p]--;
        end
      end
      cyc++;
    end
  end

  function automatic bit drained();
    int s;
    s = 0;
    for (int p = 0; p < NP; p++) begin
      if (tx_seq[p] != req_flits[p]) return 1'b0;
      s += tx_seq[p];
    end
    for (int l = 0; l < NL; l++)
      for (int v = 0; v < NV; v++)
        if (pend[l][v] != 0) return 1'b0;
    return s == rx_total;
  endfunction

  task automatic wait_drain(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (drained()) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, failures + mon_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1'b1;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", rx_total, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, failures + mon_fails + 1);
    $finish;
  end

  initial begin
    int base, snap[NL][NV], lsnap[NL], cnt;
    // R1: idle during and after reset
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(in_credit == '0, "R1", "in_credit in reset", int'(in_credit), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_credit == '0, "R1", "in_credit after reset", int'(in_credit), 0);
    ret_en = 1'b1;

    // R2/R7: one packet from port 0
    req_flits[0] = PKT;
    wait_drain(500);
    chk(rx_total == PKT, "R2", "single packet flits", rx_total, PKT);
    chk(cred_pulse[0] == PKT, "R7", "credit pulses port 0", cred_pulse[0], PKT);

    // R3/R8: credits withheld
    ret_en = 1'b0;
    base = rx_total;
    snap = vc_cnt;
    for (int p = 0; p < NP; p++) req_flits[p] += PKT;
    repeat (120) @(negedge clk);
    chk(rx_total - base == NP * PKT, "R3", "first round delivered", rx_total - base, NP * PKT);
    for (int l = 0; l < NL; l++)
      for (int v = 0; v < NV; v++) begin
        cnt = vc_cnt[l][v] - snap[l][v];
        chk(cnt == 0 || cnt == CRED, "R3", "per-VC flits round 1", cnt, CRED);
      end
    for (int p = 0; p < NP; p++) req_flits[p] += PKT;
    repeat (150) @(negedge clk);
    chk(rx_total - base == 2 * NP * PKT, "R3", "second round delivered", rx_total - base, 2 * NP * PKT);
    for (int l = 0; l < NL; l++)
      for (int v = 0; v < NV; v++) begin
        cnt = vc_cnt[l][v] - snap[l][v];
        chk(cnt == CRED, "R3", "per-VC flits exhausted", cnt, CRED);
      end
    req_flits[0] += PKT;
    repeat (150) @(negedge clk);
    chk(rx_total - base == 2 * NP * PKT, "R3", "stall without credit", rx_total - base, 2 * NP * PKT);
    ret_en = 1'b1;
    wait_drain(1000);
    chk(rx_total - base == 2 * NP * PKT + PKT, "R8", "resume after credits", rx_total - base,
        2 * NP * PKT + PKT);

    // R5/R6: all ports saturated
    base = rx_total;
    lsnap = layer_pkts;
    for (int p = 0; p < NP; p++) req_flits[p] += SAT_PKTS * PKT;
    wait_drain(40000);
    chk(rx_total - base == NP * SAT_PKTS * PKT, "R6", "all packets delivered", rx_total - base,
        NP * SAT_PKTS * PKT);
    for (int l = 0; l < NL; l++) begin
      cnt = layer_pkts[l] - lsnap[l];
      chk(cnt * 8 >= NP * SAT_PKTS, "R5", "layer share", cnt, NP * SAT_PKTS / NL);
    end
    for (int p = 0; p < NP; p++) begin
      chk(cred_pulse[p] == tx_seq[p], "R7", "credit pulses", cred_pulse[p], tx_seq[p]);
      chk(exp_seq[p] == tx_seq[p], "R2", "flits received", exp_seq[p], tx_seq[p]);
      chk(up_cred[p] == DEPTH, "R7", "upstream credits restored", up_cred[p], DEPTH);
    end
    for (int l = 0; l < NL; l++)
      for (int v = 0; v < NV; v++)
        chk(outst[l][v] == 0, "R3", "outstanding after drain", outst[l][v], 0);

    if (!wd_fail) finish_run();
  end

endmodule